// File: doc/BRIEF.md
# Wide Candidate Move Serializer

This block sits behind a parallel move generator that produces, in a single transfer, every candidate move for nine target squares of one board rank. Each target square owns twenty candidate slots, enough for ten pieces that can each reach the square with or without promotion. Every slot carries a valid bit and a 24-bit move word that names the moving piece and its destination. The whole 180-slot vector is captured in one cycle.

The block then drains that sparse vector into a dense stream of one 24-bit move per clock, guarded by a valid/ready handshake. A priority picker always presents the lowest-numbered pending slot. Each accepted beat clears that slot's pending bit. When nothing is pending, a one-cycle completion strobe is raised and the block becomes ready for the next load. The time from a load until the block is ready again is a fixed overhead plus one cycle per valid move. It does not depend on the number of slots.

Top module: `move_serializer`

## Requirements
- R1: After reset, `idle_o` is 1 and `mv_valid_o` and `done_o` are 0. While `idle_o` is 1, `mv_valid_o` and `done_o` stay 0.
- R2: When `ld_i` is 1 in a cycle where `idle_o` is 1, all slots are captured. Slot (square s, slot k) has flat index i = s*20 + k, its valid bit is `slot_vld_i[i]`, and its word is `slot_word_i[i*24 +: 24]`. The first beat is offered in the cycle after the load.
- R3: Beats are emitted in strictly ascending flat index.
- R4: Each beat's word equals the word captured at load for that slot. Changes on `slot_vld_i` and `slot_word_i` after the load have no effect on the stream.
- R5: Every captured valid slot is emitted exactly once. The number of beats equals the number of valid bits loaded.
- R6: While `mv_valid_o` is 1 and `mv_ready_i` is 0, the next cycle shows the same beat: valid is still 1, and the word and last flag are unchanged.
- R7: `mv_last_o` is 1 on the final beat of a load and 0 on every other beat.
- R8: `done_o` is a one-cycle pulse in the cycle after the final beat is accepted. If the load had no valid slot, it appears in the cycle after the load. `idle_o` returns to 1 in the cycle after `done_o`.
- R9: A load request while `idle_o` is 0 is ignored, and the stream in progress continues unchanged.
- R10: With `mv_ready_i` held at 1, `done_o` appears exactly N+1 cycles after the load cycle, where N is the number of valid slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Load request, taken only while idle |
| slot_vld_i | input | 180 | Valid bit per slot, flat index s*20+k |
| slot_word_i | input | 4320 | 24-bit move word per slot, same indexing |
| idle_o | output | 1 | Block can accept a load |
| done_o | output | 1 | One-cycle pulse: all moves of the load have been sent |
| mv_valid_o | output | 1 | Output beat available |
| mv_ready_i | input | 1 | Consumer accepts the beat |
| mv_word_o | output | 24 | Move word of the current beat |
| mv_last_o | output | 1 | Current beat is the final one of the load |

## Verification
A pending bit that fails to clear appears at the ports within one cycle of the beat being accepted: the same word is offered twice, or the index goes backwards. A bit that clears when it should not appears as a missing word, and the beat count and the timing of `done_o` are both off by the end of the load. A wrong pick shows on the very next beat as a word out of ascending order. A faulty load gate shows either as a stream that differs from the first load or as `idle_o` returning too early. The bench compares every beat against a queue built from the mask and checks the cycle in which `done_o` arrives.

// File: rtl/msr_pkg.sv
package msr_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } msr_state_e;

  // flat slot position: squares first, then slot within the square
  function automatic int unsigned slot_flat(input int unsigned sq,
                                            input int unsigned sl,
                                            input int unsigned nslot);
    return sq * nslot + sl;
  endfunction

endpackage

// File: rtl/msr_store.sv
module msr_store #(
  parameter int NSQ   = 9,
  parameter int NSLOT = 20,
  parameter int MW    = 24,
  localparam int NTOT = NSQ * NSLOT,
  localparam int IW   = $clog2(NTOT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap,
  input  logic [NTOT-1:0]          vld_in,
  input  logic [NTOT*MW-1:0]       word_in,
  input  logic                     clr,
  input  logic [IW-1:0]            clr_idx,
  output logic [NTOT-1:0]          pend,
  output logic [NTOT-1:0][MW-1:0]  words
);
  import msr_pkg::*;

  logic [NTOT-1:0] clr_mask;
  assign clr_mask = NTOT'(1) << clr_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= '0;
    else if (cap) pend <= vld_in;
    else if (clr) pend <= pend & ~clr_mask;
  end

  for (genvar s = 0; s < NSQ; s++) begin : g_sq
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      localparam int unsigned FI = slot_flat(s, k, NSLOT);
      always_ff @(posedge clk) begin
        if (cap) words[FI] <= word_in[FI*MW +: MW];
      end
    end
  end

  // R5: one accepted beat removes exactly one pending slot
  a_r5_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ($countones(pend) + 1 == $past($countones(pend))));

endmodule

// File: rtl/msr_pick.sv
module msr_pick #(
  parameter int N  = 180,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic          multi
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any   = |req;
  assign multi = |(req & (req - N'(1)));

  // R3: the picked position is a pending one
  a_r3_pick_pending: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx]);

endmodule

// File: rtl/move_serializer.sv
module move_serializer #(
  parameter int NSQ   = 9,
  parameter int NSLOT = 20,
  parameter int MW    = 24,
  localparam int NTOT = NSQ * NSLOT,
  localparam int IW   = $clog2(NTOT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_i,
  input  logic [NTOT-1:0]    slot_vld_i,
  input  logic [NTOT*MW-1:0] slot_word_i,
  output logic               idle_o,
  output logic               done_o,
  output logic               mv_valid_o,
  input  logic               mv_ready_i,
  output logic [MW-1:0]      mv_word_o,
  output logic               mv_last_o
);
  import msr_pkg::*;

  msr_state_e               state;
  logic                     accept;
  logic                     fire;
  logic [NTOT-1:0]          pend;
  logic [NTOT-1:0][MW-1:0]  words;
  logic                     pick_any;
  logic                     pick_multi;
  logic [IW-1:0]            pick_idx;

  assign accept = ld_i && (state == ST_IDLE);
  assign fire   = mv_valid_o && mv_ready_i;

  msr_store #(.NSQ(NSQ), .NSLOT(NSLOT), .MW(MW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (accept),
    .vld_in  (slot_vld_i),
    .word_in (slot_word_i),
    .clr     (fire),
    .clr_idx (pick_idx),
    .pend    (pend),
    .words   (words)
  );

  msr_pick #(.N(NTOT)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (pend),
    .any   (pick_any),
    .idx   (pick_idx),
    .multi (pick_multi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= ST_IDLE;
    else if (accept) state <= ST_DRAIN;
    else if (done_o) state <= ST_IDLE;
  end

  assign idle_o     = (state == ST_IDLE);
  assign mv_valid_o = (state == ST_DRAIN) && pick_any;
  assign done_o     = (state == ST_DRAIN) && !pick_any;
  assign mv_word_o  = words[pick_idx];
  assign mv_last_o  = mv_valid_o && !pick_multi;

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (!mv_valid_o && !done_o));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mv_last_o) |=> (mv_valid_o && (pick_idx > $past(pick_idx))));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid_o && !mv_ready_i) |=>
      (mv_valid_o && $stable(mv_word_o) && $stable(mv_last_o)));

  a_r7_last_done: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mv_last_o) |=> done_o);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (idle_o && !done_o));

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && !done_o) |=> !idle_o);

endmodule

// File: tb/sim_move_serializer.sv
module sim_move_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 9, NK = 20, W = 24, NT = NS * NK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_i = 1'b0;
  logic [NT-1:0] slot_vld_i = '0;
  logic [NT*W-1:0] slot_word_i = '0;
  logic idle_o, done_o, mv_valid_o, mv_last_o;
  logic mv_ready_i = 1'b1;
  logic [W-1:0] mv_word_o;

  int checks = 0;
  int errors = 0;

  logic [NT-1:0] vin;
  logic [NT*W-1:0] win;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  move_serializer #(.NSQ(NS), .NSLOT(NK), .MW(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i),
    .slot_vld_i(slot_vld_i), .slot_word_i(slot_word_i),
    .idle_o(idle_o), .done_o(done_o),
    .mv_valid_o(mv_valid_o), .mv_ready_i(mv_ready_i),
    .mv_word_o(mv_word_o), .mv_last_o(mv_last_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_words();
    for (int i = 0; i < NT; i++) win[i*W +: W] = W'($urandom);
  endtask

  task automatic fill_mask(input int pct);
    for (int i = 0; i < NT; i++) vin[i] = (($urandom % 100) < pct);
  endtask

  // one load, drained to completion; stall: random back-pressure; poke: load while busy
  task automatic run_load(input bit stall, input bit poke);
    int beats, c;
    bit seen_done, prev_stall, rdy;
    logic [W-1:0] prev_word;
    exp_q.delete();
    for (int i = 0; i < NT; i++) if (vin[i]) exp_q.push_back(i);
    @(negedge clk);
    chk(idle_o == 1'b1, "R2 idle before load", idle_o, 1);
    ld_i = 1'b1; slot_vld_i = vin; slot_word_i = win;
    @(negedge clk);
    ld_i = 1'b0;
    slot_vld_i = ~vin; slot_word_i = ~win;   // R4: post-load input changes ignored
    beats = 0; c = 1; seen_done = 0; prev_stall = 0; prev_word = '0;
    while (!seen_done && c < 3000) begin
      ld_i = 1'b0;
      rdy = stall ? (($urandom % 3) != 0) : 1'b1;
      mv_ready_i = rdy;
      if (prev_stall)
        chk(mv_valid_o && mv_word_o == prev_word, "R6 stalled beat held", mv_word_o, prev_word);
      if (mv_valid_o) begin
        if (beats >= exp_q.size()) begin
          chk(1'b0, "R5 extra beat", beats, exp_q.size());
        end else begin
          chk(mv_word_o == win[exp_q[beats]*W +: W], "R3/R4 beat word and order",
              mv_word_o, win[exp_q[beats]*W +: W]);
          chk(mv_last_o == (beats == exp_q.size() - 1), "R7 last flag",
              mv_last_o, (beats == exp_q.size() - 1));
          if (beats == 0 && !stall)
            chk(c == 1, "R2 first beat one cycle after load", c, 1);
          if (rdy) beats++;
        end
      end
      if (done_o) begin
        seen_done = 1;
        chk(beats == exp_q.size(), "R5 beat count", beats, exp_q.size());
        chk(!mv_valid_o, "R8 no beat with done", mv_valid_o, 0);
        if (!stall) chk(c == exp_q.size() + 1, "R10 cycles to done", c, exp_q.size() + 1);
      end
      if (poke && c == 2) begin
        ld_i = 1'b1;   // R9: load while busy
      end
      prev_stall = mv_valid_o && !rdy;
      prev_word = mv_word_o;
      @(negedge clk);
      c++;
    end
    ld_i = 1'b0;
    mv_ready_i = 1'b1;
    chk(seen_done, "R8 done seen", seen_done, 1);
    chk(idle_o && !done_o, "R8 idle after done pulse", {idle_o, done_o}, 2'b10);
  endtask

  task automatic t_reset();
    chk(idle_o == 1'b1, "R1 idle at reset", idle_o, 1);
    chk(mv_valid_o == 1'b0, "R1 no beat at reset", mv_valid_o, 0);
    chk(done_o == 1'b0, "R1 no done at reset", done_o, 0);
  endtask

  task automatic t_empty();
    vin = '0; fill_words(); run_load(0, 0);
  endtask

  task automatic t_single_top();
    vin = '0; vin[NT-1] = 1'b1; fill_words(); run_load(0, 0);
  endtask

  task automatic t_square_edges();
    vin = '0;
    for (int s = 0; s < NS; s++) begin
      vin[s*NK] = 1'b1; vin[s*NK + NK - 1] = 1'b1;
    end
    fill_words(); run_load(0, 0);
  endtask

  task automatic t_full();
    vin = '1; fill_words(); run_load(0, 0);
  endtask

  task automatic t_sparse_stall();
    for (int r = 0; r < 4; r++) begin
      fill_mask(5 + r * 10); fill_words(); run_load(1, 0);
    end
  endtask

  task automatic t_busy_load();
    fill_mask(40); fill_words(); run_load(0, 1);
    fill_mask(30); fill_words(); run_load(1, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_single_top();
    t_square_edges();
    t_full();
    t_sparse_stall();
    t_busy_load();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule